// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a synthesizable model of a synchronous, pipelined burst SRAM with single-cycle deselect. It holds a small internal array 18 bits wide, split into two 9-bit lanes, with a parameterized depth. All address and control inputs are registered on the rising clock edge. Read data passes through an output register, so a read appears one cycle after the edge that performs it.

An access starts on one of two address strobes. The host strobe starts a two-edge write. The cache strobe starts a single-edge write. After the start, a 2-bit burst sequencer walks through the four words of the aligned group, in either linear or interleaved order. The data bus is split into `dataIn`, `dataOut` and a drive qualifier `dataOe`. A sleep request puts the device into power-down. The array contents survive power-down.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A synchronous active-high `rst` leaves `dataOe` at 0 in the cycle after reset. Array contents written before reset read back unchanged afterwards.
- R2: A strobe edge whose enables are not all active deselects the device. All enables are active when `selPrimN`=0, `selHigh`=1 and `selAuxN`=0. In the following cycle `dataOe` is 0, and later edges without a strobe perform no access.
- R3: `hostStartN` is ignored while `selPrimN` is 1. When both strobes are low and the host strobe is honoured, that edge behaves as a host start. The write inputs are not used, so nothing is written and the addressed word is read.
- R4: A read edge on a selected device loads the addressed word into the output register. The word is on `dataOut` with `dataOe`=1 in the cycle right after that edge, provided `outEnN` is 0.
- R5: A host-strobe start always performs a read at its own edge. The write inputs and the data are sampled at the next edge. There the write goes to the same address, and `stepN` is ignored.
- R6: A cache-strobe start with the write inputs active writes `dataIn` at that same edge. `stepN` has no effect on that edge.
- R7: The write decode works as follows. `wrAllN`=0 writes both lanes. Otherwise `wrLaneEnN`=0 writes lane 0 (bits 8:0) when `wrLaneN[0]`=0 and lane 1 (bits 17:9) when `wrLaneN[1]`=0. If both lane selects are 1, or `wrLaneEnN`=1, the edge is a read.
- R8: The cycle after a start edge that selects a deselected device keeps `dataOe` at 0. From the cycle after that, `outEnN` controls the bus.
- R9: `outEnN` acts without a clock edge: while it is 1, `dataOe` is 0. In the cycle after a write edge, `dataOe` is 0.
- R10: An edge with no strobe continues the burst. With `stepN`=0 it moves to the next word of the group. With `stepN`=1 it stays on the current word. The order within the group is the low two address bits plus the step count modulo 4 when `interleaved`=0, and those bits XOR the step count when `interleaved`=1. A change of `interleaved` takes effect one edge later.
- R11: `sleepReq` passes through a two-flop synchronizer. From the second edge after it is raised, the device is powered down: `dataOe` is 0 and strobes are ignored. Once the synchronized request clears, strobes stay ignored for `WAKE_CYCLES` more edges. Array contents are preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the control state |
| selPrimN | input | 1 | Primary enable, active low; also masks the host strobe |
| selHigh | input | 1 | Enable, active high |
| selAuxN | input | 1 | Auxiliary enable, active low |
| hostStartN | input | 1 | Host address strobe, active low |
| cacheStartN | input | 1 | Cache address strobe, active low |
| stepN | input | 1 | Burst step, active low |
| wrAllN | input | 1 | Write both lanes, active low |
| wrLaneEnN | input | 1 | Lane write enable, active low |
| wrLaneN | input | 2 | Per-lane write selects, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepReq | input | 1 | Power-down request |
| interleaved | input | 1 | 1 = interleaved burst order, 0 = linear |
| addr | input | ADDR_W | Word address |
| dataIn | input | 18 | Write data |
| dataOut | output | 18 | Output register contents |
| dataOe | output | 1 | Bus drive qualifier for dataOut |

## Verification
The assertions assume that `sleepReq` is low while `rst` is applied, so the synchronizer never starts from a mismatched state. They also assume that the enables and strobes carry known values at every edge. The stimulus drives every input at the falling edge and keeps `sleepReq` low through both reset pulses. Each scenario also returns the bus to an idle pattern, strobes high and write inputs inactive, before the next one starts.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int DATA_W = 18;
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;
  localparam int CNT_W  = 2;

  // Strobes handed from the control to the datapath for one edge.
  typedef struct packed {
    logic             memWe;
    logic [LANES-1:0] wrMask;
    logic             rdEn;
    logic             hideOut;
  } ctl_t;
endpackage

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] startLow,
  input  logic [CNT_W-1:0] step,
  input  logic             interleaved,
  output logic [CNT_W-1:0] seqLow
);
  // Interleaved order flips bits of the start; linear order adds modulo 2^CNT_W.
  always_comb seqLow = interleaved ? (startLow ^ step) : (startLow + step);
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl import bsram_pkg::*; #(
  parameter int ADDR_W      = 8,
  parameter int WAKE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selPrimN,
  input  logic              selHigh,
  input  logic              selAuxN,
  input  logic              hostStartN,
  input  logic              cacheStartN,
  input  logic              stepN,
  input  logic              wrAllN,
  input  logic              wrLaneEnN,
  input  logic [LANES-1:0]  wrLaneN,
  input  logic              sleepReq,
  input  logic              interleaved,
  input  logic [ADDR_W-1:0] addr,
  output ctl_t              ctlBus,
  output logic [ADDR_W-1:0] accAddr
);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  logic              sleepS1, sleepS2;
  logic [WAKE_W-1:0] wakeCnt;
  logic              modeReg;
  logic              active, firstSel, holdNext;
  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  cnt;

  logic              ready, enabled, hostSeen, cacheSeen, strobe;
  logic              startAcc, contAcc, wrNow, holdAddr;
  logic [LANES-1:0]  wrMaskNow;
  logic [CNT_W-1:0]  curLow, nextLow;

  bsram_burst_seq #(.CNT_W(CNT_W)) u_seqCur (
    .startLow(baseAddr[CNT_W-1:0]), .step(cnt),
    .interleaved(modeReg), .seqLow(curLow));

  bsram_burst_seq #(.CNT_W(CNT_W)) u_seqNext (
    .startLow(baseAddr[CNT_W-1:0]), .step(cnt + CNT_W'(1)),
    .interleaved(modeReg), .seqLow(nextLow));

  always_comb begin
    ready     = !sleepS2 && (wakeCnt == '0);
    enabled   = !selPrimN && selHigh && !selAuxN;
    hostSeen  = ready && !hostStartN && !selPrimN;
    cacheSeen = ready && !cacheStartN && !hostSeen;
    strobe    = hostSeen || cacheSeen;
    startAcc  = strobe && enabled;
    contAcc   = !strobe && active && ready;
    wrMaskNow = !wrAllN ? {LANES{1'b1}} : (!wrLaneEnN ? ~wrLaneN : '0);
    wrNow     = |wrMaskNow;
    holdAddr  = stepN || (holdNext && wrNow);
    accAddr   = startAcc ? addr
                         : {baseAddr[ADDR_W-1:CNT_W], (holdAddr ? curLow : nextLow)};
    ctlBus.memWe   = (startAcc && cacheSeen && wrNow) || (contAcc && wrNow);
    ctlBus.wrMask  = wrMaskNow;
    ctlBus.rdEn    = (startAcc && (hostSeen || !wrNow)) || (contAcc && !wrNow);
    ctlBus.hideOut = firstSel || sleepS2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sleepS1  <= 1'b0;
      sleepS2  <= 1'b0;
      wakeCnt  <= '0;
      modeReg  <= 1'b0;
      active   <= 1'b0;
      firstSel <= 1'b0;
      holdNext <= 1'b0;
      baseAddr <= '0;
      cnt      <= '0;
    end else begin
      sleepS1  <= sleepReq;
      sleepS2  <= sleepS1;
      modeReg  <= interleaved;
      if (sleepS2) wakeCnt <= WAKE_W'(WAKE_CYCLES);
      else if (wakeCnt != '0) wakeCnt <= wakeCnt - WAKE_W'(1);
      firstSel <= startAcc && !active;
      holdNext <= startAcc && hostSeen;
      if (sleepS2) begin
        active <= 1'b0;
      end else if (strobe) begin
        active <= enabled;
        if (startAcc) begin
          baseAddr <= addr;
          cnt      <= '0;
        end
      end else if (contAcc && !holdAddr) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bsram_datapath.sv
module bsram_datapath import bsram_pkg::*; #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctlBus,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] outReg;
  logic              outValid;
  logic [DATA_W-1:0] laneBits;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneBits[g*LANE_W +: LANE_W] = {LANE_W{ctlBus.wrMask[g]}};
  end

  always_ff @(posedge clk) begin
    if (ctlBus.memWe)
      mem[accAddr] <= (mem[accAddr] & ~laneBits) | (dataIn & laneBits);
  end

  always_ff @(posedge clk) begin
    if (ctlBus.rdEn) outReg <= mem[accAddr];
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= ctlBus.rdEn;
  end

  assign dataOut = outReg;
  assign dataOe  = outValid && !ctlBus.hideOut && !outEnN;
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl import bsram_pkg::*; #(
  parameter int DEPTH       = 256,
  parameter int WAKE_CYCLES = 2,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selPrimN,
  input  logic              selHigh,
  input  logic              selAuxN,
  input  logic              hostStartN,
  input  logic              cacheStartN,
  input  logic              stepN,
  input  logic              wrAllN,
  input  logic              wrLaneEnN,
  input  logic [LANES-1:0]  wrLaneN,
  input  logic              outEnN,
  input  logic              sleepReq,
  input  logic              interleaved,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  ctl_t              ctlBus;
  logic [ADDR_W-1:0] accAddr;

  bsram_ctrl #(.ADDR_W(ADDR_W), .WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .selPrimN(selPrimN), .selHigh(selHigh), .selAuxN(selAuxN),
    .hostStartN(hostStartN), .cacheStartN(cacheStartN), .stepN(stepN),
    .wrAllN(wrAllN), .wrLaneEnN(wrLaneEnN), .wrLaneN(wrLaneN),
    .sleepReq(sleepReq), .interleaved(interleaved), .addr(addr),
    .ctlBus(ctlBus), .accAddr(accAddr));

  bsram_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctlBus(ctlBus), .accAddr(accAddr), .dataIn(dataIn),
    .outEnN(outEnN), .dataOut(dataOut), .dataOe(dataOe));
endmodule

// File: rtl/bsram_checker.sv
module bsram_checker import bsram_pkg::*; (
  input logic clk,
  input logic rst,
  input logic selPrimN,
  input logic selHigh,
  input logic selAuxN,
  input logic hostStartN,
  input logic cacheStartN,
  input logic wrAllN,
  input logic sleepReq,
  input logic dataOe,
  input ctl_t ctlBus
);
  // R1: the bus is quiet in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !dataOe);

  // R2: a cache strobe with selHigh low deselects, bus released next cycle
  assert_deselect_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    (!cacheStartN && hostStartN && !selHigh) |=> !dataOe);

  // R5: a selected host strobe never writes on its own edge
  assert_host_first_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!hostStartN && !selPrimN && selHigh && !selAuxN) |-> !ctlBus.memWe);

  // R6: a selected cache-strobe write leaves the bus undriven next cycle
  assert_cache_write_hiz_R6: assert property (@(posedge clk) disable iff (rst)
    (!cacheStartN && hostStartN && !selPrimN && selHigh && !selAuxN && !wrAllN) |=> !dataOe);

  // R11: a held sleep request releases the bus
  assert_sleep_hiz_R11: assert property (@(posedge clk) disable iff (rst)
    (sleepReq && $past(sleepReq) && !$past(rst)) |=> !dataOe);
endmodule

bind burst_sram_ctrl bsram_checker u_chk (
  .clk(clk), .rst(rst), .selPrimN(selPrimN), .selHigh(selHigh), .selAuxN(selAuxN),
  .hostStartN(hostStartN), .cacheStartN(cacheStartN), .wrAllN(wrAllN),
  .sleepReq(sleepReq), .dataOe(dataOe), .ctlBus(ctlBus));

// File: tb/burst_sram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst, selPrimN, selHigh, selAuxN, hostStartN, cacheStartN, stepN;
  logic        wrAllN, wrLaneEnN, outEnN, sleepReq, interleaved;
  logic [1:0]  wrLaneN;
  logic [7:0]  addr;
  logic [17:0] dataIn, dataOut;
  logic        dataOe;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  burst_sram_ctrl u_dut (
    .clk(clk), .rst(rst), .selPrimN(selPrimN), .selHigh(selHigh), .selAuxN(selAuxN),
    .hostStartN(hostStartN), .cacheStartN(cacheStartN), .stepN(stepN),
    .wrAllN(wrAllN), .wrLaneEnN(wrLaneEnN), .wrLaneN(wrLaneN), .outEnN(outEnN),
    .sleepReq(sleepReq), .interleaved(interleaved), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    selPrimN = 0; selHigh = 1; selAuxN = 0;
    hostStartN = 1; cacheStartN = 1; stepN = 1;
    wrAllN = 1; wrLaneEnN = 1; wrLaneN = 2'b11; outEnN = 0;
  endtask

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expOut(string tag, logic [17:0] exp);
    chk({tag, " drive"}, {17'd0, dataOe}, 18'd1);
    chk({tag, " data"}, dataOut, exp);
  endtask

  task automatic expHiZ(string tag);
    chk({tag, " hiz"}, {17'd0, dataOe}, 18'd0);
  endtask

  task automatic cacheAccess(logic [7:0] a, logic wa, logic we, logic [1:0] wl, logic [17:0] d);
    idle();
    cacheStartN = 0; addr = a; wrAllN = wa; wrLaneEnN = we; wrLaneN = wl; dataIn = d;
    tick();
    idle();
  endtask

  task automatic cacheWrite(logic [7:0] a, logic [17:0] d);
    cacheAccess(a, 1'b0, 1'b1, 2'b11, d);
  endtask

  task automatic cacheRead(logic [7:0] a);
    cacheAccess(a, 1'b1, 1'b1, 2'b11, 18'd0);
  endtask

  task automatic deselect();
    idle(); cacheStartN = 0; selHigh = 0;
    tick();
    idle();
  endtask

  // Read start plus one holding edge, so the word is visible even after reselect.
  task automatic readBack(string tag, logic [7:0] a, logic [17:0] exp);
    cacheRead(a);
    tick();
    expOut(tag, exp);
  endtask

  task automatic test_reset_r1();
    expHiZ("R1 after reset");
    cacheWrite(8'h05, 18'h1ABCD);
    rst = 1; tick(); tick(); rst = 0;
    expHiZ("R1 after second reset");
    readBack("R1 array kept", 8'h05, 18'h1ABCD);
  endtask

  task automatic test_single_r4_r6_r9();
    cacheWrite(8'h10, 18'h2A5A5);
    expHiZ("R9 after write edge");
    cacheRead(8'h10);
    expOut("R4 one-cycle read", 18'h2A5A5);
    outEnN = 1; #1;
    expHiZ("R9 outEnN high");
    outEnN = 0; #1;
    expOut("R9 outEnN low again", 18'h2A5A5);
    readBack("R6 single-edge write", 8'h10, 18'h2A5A5);
  endtask

  task automatic test_reselect_r2_r8();
    deselect();
    expHiZ("R2 deselect");
    tick();
    expHiZ("R2 idle while deselected");
    cacheRead(8'h10);
    expHiZ("R8 first cycle after reselect");
    tick();
    expOut("R8 second cycle after reselect", 18'h2A5A5);
  endtask

  task automatic test_lanes_r7();
    cacheWrite(8'h20, 18'h3FFFF);
    cacheAccess(8'h20, 1'b1, 1'b0, 2'b10, 18'h00000);
    readBack("R7 lane0 only", 8'h20, 18'h3FE00);
    cacheAccess(8'h20, 1'b1, 1'b0, 2'b01, 18'h15555);
    readBack("R7 lane1 only", 8'h20, 18'h15400);
    cacheAccess(8'h20, 1'b1, 1'b0, 2'b11, 18'h00000);
    expOut("R7 no lane selected reads", 18'h15400);
    cacheAccess(8'h20, 1'b0, 1'b1, 2'b11, 18'h0F0F0);
    readBack("R7 write-all overrides", 8'h20, 18'h0F0F0);
  endtask

  task automatic test_host_write_r5();
    cacheWrite(8'h30, 18'h00111);
    cacheWrite(8'h31, 18'h00333);
    idle(); hostStartN = 0; addr = 8'h30; wrAllN = 0; dataIn = 18'h2DEAD;
    tick();
    expOut("R5 first edge reads", 18'h00111);
    idle(); wrAllN = 0; stepN = 0; dataIn = 18'h00222; addr = 8'h31;
    tick();
    idle();
    expHiZ("R5 second edge writes");
    readBack("R5 written at start address", 8'h30, 18'h00222);
    readBack("R5 step ignored", 8'h31, 18'h00333);
  endtask

  task automatic test_priority_r3();
    cacheWrite(8'h60, 18'h0AAAA);
    idle(); hostStartN = 0; cacheStartN = 0; addr = 8'h60; wrAllN = 0; dataIn = 18'h3FFFF;
    tick();
    idle();
    expOut("R3 both strobes host wins", 18'h0AAAA);
    tick();
    readBack("R3 no write by cache", 8'h60, 18'h0AAAA);
    deselect();
    idle(); hostStartN = 0; selPrimN = 1; addr = 8'h60; wrAllN = 0; dataIn = 18'h00000;
    tick();
    idle();
    expHiZ("R3 masked host strobe");
    readBack("R3 masked host no write", 8'h60, 18'h0AAAA);
  endtask

  task automatic test_burst_r10();
    interleaved = 0;
    cacheWrite(8'h40, 18'h00100);
    for (int i = 1; i < 4; i++) begin
      idle(); wrAllN = 0; stepN = 0; dataIn = 18'(18'h00100 + i);
      tick();
    end
    idle();
    cacheRead(8'h41);
    expOut("R10 linear start", 18'h00101);
    stepN = 0; tick(); expOut("R10 linear step1", 18'h00102);
    stepN = 1; tick(); expOut("R10 hold", 18'h00102);
    stepN = 0; tick(); expOut("R10 linear step2", 18'h00103);
    stepN = 0; tick(); expOut("R10 linear wrap", 18'h00100);
    idle(); interleaved = 1;
    tick();
    cacheRead(8'h41);
    expOut("R10 interleaved start", 18'h00101);
    stepN = 0; tick(); expOut("R10 interleaved step1", 18'h00100);
    stepN = 0; tick(); expOut("R10 interleaved step2", 18'h00103);
    stepN = 0; tick(); expOut("R10 interleaved step3", 18'h00102);
    idle(); interleaved = 0;
    tick();
  endtask

  task automatic test_sleep_r11();
    cacheWrite(8'h50, 18'h12345);
    cacheRead(8'h50);
    expOut("R11 before sleep", 18'h12345);
    sleepReq = 1;
    tick(); tick();
    expHiZ("R11 powered down");
    cacheWrite(8'h50, 18'h3FFFF);
    expHiZ("R11 still down");
    sleepReq = 0;
    tick(); tick();
    cacheWrite(8'h50, 18'h00001);
    for (int i = 0; i < 4; i++) tick();
    readBack("R11 contents kept", 8'h50, 18'h12345);
  endtask

  initial begin
    idle();
    rst = 1; sleepReq = 0; interleaved = 0; addr = '0; dataIn = '0;
    tick(); tick(); tick();
    rst = 0;
    test_reset_r1();
    test_single_r4_r6_r9();
    test_reselect_r2_r8();
    test_lanes_r7();
    test_host_write_r5();
    test_priority_r3();
    test_burst_r10();
    test_sleep_r11();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule